// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends characters on a single asynchronous serial line. The CPU writes a character into a holding register. A separate shift register moves the character onto the line, one bit per pulse of an external bit-rate tick. Because the two registers are separate, the next character can be written while the current one is still on the wire, and consecutive frames leave with no idle gap between them.

Two status flags are kept. The holding-empty flag is high when the holding register can take a new character. The line-done flag is high when no frame is in progress. Each flag has its own interrupt enable, and the two enabled flags are ORed into one interrupt request. A length input selects frames of 8 or 9 data bits. The ninth bit comes from a separate input. A break input holds the line low while the transmitter is idle.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, `hold_empty` = 1, `line_done` = 1 and `txd` = 1, and with both interrupt enables at 0, `irq` = 0.
- R2: A write (`wr_en` = 1) while `hold_empty` = 0 is ignored. The character already held stays unchanged and is the one that gets sent.
- R3: An accepted write drives `hold_empty` to 0 on the next cycle. When `tx_en` = 1 and a character is held, the frame starts at the next `bit_tick`: `txd` goes to 0 and `line_done` goes to 0 at that same edge.
- R4: With `len9` = 0, a frame is 10 bit periods long. It is a start bit of 0, then the 8 data bits least significant first, then a stop bit of 1. Each bit period lasts from one `bit_tick` to the next.
- R5: With `len9` = 1, a frame is 11 bit periods long. The value of `bit8` is sent as the ninth data bit, between data bit 7 and the stop bit. `len9` and `bit8` are sampled when the frame starts.
- R6: When a frame ends and no character is held (or `tx_en` = 0), `line_done` returns to 1. With nothing held, both flags then read 1.
- R7: `irq` = (`hold_empty` AND `ie_empty`) OR (`line_done` AND `ie_done`).
- R8: `hold_empty` returns to 1 at the tick where the held character moves into the shift register. A character written during a frame starts at the tick that ends the previous stop bit, with no idle period in between.
- R9: While `brk` = 1, a frame in progress finishes normally. After that, `txd` stays 0 for as long as `brk` remains 1, and goes back to 1 in the cycle after `brk` falls.
- R10: With `tx_en` = 0, no new frame starts. A frame already in progress completes, after which `txd` holds at 1 and a held character remains held (`hold_empty` = 0, `line_done` = 1) until `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to write |
| tx_en | input | 1 | Transmit enable |
| len9 | input | 1 | 0: 8 data bits, 1: 9 data bits |
| bit8 | input | 1 | Ninth data bit for 9-bit frames |
| brk | input | 1 | Send break while idle |
| ie_empty | input | 1 | Interrupt enable for hold_empty |
| ie_done | input | 1 | Interrupt enable for line_done |
| txd | output | 1 | Serial line, idles at 1 |
| hold_empty | output | 1 | Holding register can accept a character |
| line_done | output | 1 | No frame in progress |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is the back-to-back handoff. A second character has to be written after the first has moved into the shift register but before the first frame's stop bit ends. The stimulus gets there by polling `hold_empty` until it rises again, writing immediately, and then checking that the next start bit follows the previous stop bit within one bit period. The break and disable cases are handled the same way. The stimulus waits for `line_done` to fall, which shows a frame has begun, and only then changes `brk` or `tx_en`. The frame in flight is then decoded to show it was unaffected.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_SHIFT = 1'b1} tx_state_e;
endpackage

// File: rtl/sertx_rst_sync.sv
module sertx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              full
);
  logic              full_d;
  logic              data_en;

  always_comb begin
    data_en = wr_en && !full;
    full_d  = full;
    if (take)    full_d = 1'b0;
    if (data_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_data <= '0;
    else if (data_en) hold_data <= wr_data;
  end

  // R2: a write into a full register leaves the held character untouched
  assert_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(hold_data));

  // R2: a write into a full register does not disturb its full state
  assert_full_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !take) |=> full);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              len9,
  input  logic              bit8_in,
  input  logic              brk,
  input  logic              pending,
  input  logic [DATA_W-1:0] din,
  output logic              take,
  output logic              txd,
  output logic              busy
);
  localparam int SR_W  = DATA_W + 2;
  localparam int CNT_W = $clog2(SR_W + 1);

  tx_state_e         state_q, state_d;
  logic [SR_W-1:0]   sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              line_q, line_d;
  logic              last_bit;

  assign last_bit = (cnt_q == '0);
  assign take     = bit_tick && tx_en && pending &&
                    ((state_q == TX_IDLE) || last_bit);

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    line_d  = line_q;
    if (bit_tick) begin
      if (take) begin
        state_d = TX_SHIFT;
        line_d  = 1'b0;
        sr_d    = {1'b1, (len9 ? bit8_in : 1'b1), din};
        cnt_d   = len9 ? CNT_W'(SR_W) : CNT_W'(SR_W - 1);
      end else if (state_q == TX_SHIFT) begin
        if (last_bit) begin
          state_d = TX_IDLE;
          line_d  = 1'b1;
        end else begin
          line_d  = sr_q[0];
          sr_d    = {1'b1, sr_q[SR_W-1:1]};
          cnt_d   = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sr_q    <= '1;
      cnt_q   <= '0;
      line_q  <= 1'b1;
    end else if (bit_tick) begin
      state_q <= state_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      line_q  <= line_d;
    end
  end

  assign busy = (state_q == TX_SHIFT);
  assign txd  = busy ? line_q : !brk;

  // R4: every frame opens with a low start bit
  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  // R4: during a frame the line moves only at bit ticks
  assert_tick_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> $stable(txd));

  // R6: the bit just before the frame ends is a high stop bit
  assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              len9,
  input  logic              bit8,
  input  logic              brk,
  input  logic              ie_empty,
  input  logic              ie_done,
  output logic              txd,
  output logic              hold_empty,
  output logic              line_done,
  output logic              irq
);
  logic              rst_int_n;
  logic              take_w;
  logic              full_w;
  logic              busy_w;
  logic [DATA_W-1:0] held_w;

  sertx_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (take_w),
    .hold_data (held_w),
    .full      (full_w)
  );

  sertx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_tick (bit_tick),
    .tx_en    (tx_en),
    .len9     (len9),
    .bit8_in  (bit8),
    .brk      (brk),
    .pending  (full_w),
    .din      (held_w),
    .take     (take_w),
    .txd      (txd),
    .busy     (busy_w)
  );

  assign hold_empty = !full_w;
  assign line_done  = !busy_w;
  assign irq        = (hold_empty && ie_empty) || (line_done && ie_done);

  // R3: a frame begins only with transmit enabled and a character held
  assert_start_needs_char_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(line_done) |-> ($past(!hold_empty) && $past(tx_en)));

  // R8: the holding register empties only by handing its character over
  assert_empty_on_transfer_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(hold_empty) |-> !line_done);
endmodule

// File: tb/dbuf_serial_tx_test.sv
`timescale 1ns/1ps
module dbuf_serial_tx_test;
  localparam int TP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic tx_en = 1'b0, len9 = 1'b0, bit8 = 1'b0, brk = 1'b0;
  logic ie_empty = 1'b0, ie_done = 1'b0;
  logic txd, hold_empty, line_done, irq;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  dbuf_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .tx_en(tx_en), .len9(len9), .bit8(bit8), .brk(brk),
    .ie_empty(ie_empty), .ie_done(ie_done), .txd(txd),
    .hold_empty(hold_empty), .line_done(line_done), .irq(irq)
  );

  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      tcnt++;
      bit_tick = (tcnt % TP == 0);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic get_frame(input int nbits, input int tmo,
                           output logic [10:0] bits, output bit ok);
    int waited = 0;
    bits = '1;
    while (txd !== 1'b0 && waited < tmo) begin
      @(negedge clk); waited++;
    end
    ok = (txd === 1'b0);
    if (ok) begin
      repeat (TP/2) @(negedge clk);
      bits[0] = txd;
      for (int i = 1; i < nbits; i++) begin
        repeat (TP) @(negedge clk);
        bits[i] = txd;
      end
    end
  endtask

  task automatic wait_busy();
    int n = 0;
    while (line_done !== 1'b0 && n < 3*TP) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic t_reset();
    chk("R1 hold_empty", hold_empty, 1);
    chk("R1 line_done", line_done, 1);
    chk("R1 txd", txd, 1);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_frame8();
    logic [10:0] b; bit ok;
    tx_en = 1'b1;
    wr(8'hA5);
    chk("R3 empty after write", hold_empty, 0);
    get_frame(10, 3*TP, b, ok);
    chk("R3 frame started", ok, 1);
    chk("R4 frame 8-bit A5", b[9:0], {1'b1, 8'hA5, 1'b0});
    chk("R3 busy in frame", line_done, 0);
    chk("R8 empty after transfer", hold_empty, 1);
    repeat (TP) @(negedge clk);
    chk("R6 done after frame", line_done, 1);
    chk("R6 empty after frame", hold_empty, 1);
    chk("R4 idle high", txd, 1);
  endtask

  task automatic t_ignore();
    logic [10:0] b; bit ok; int lows = 0;
    tx_en = 1'b0;
    wr(8'h3C);
    wr(8'hFF);
    chk("R2 still full", hold_empty, 0);
    tx_en = 1'b1;
    get_frame(10, 3*TP, b, ok);
    chk("R2 held char sent", b[9:0], {1'b1, 8'h3C, 1'b0});
    repeat (TP) @(negedge clk);
    for (int i = 0; i < 12*TP; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R2 no second frame", lows, 0);
    chk("R2 flags empty", hold_empty, 1);
  endtask

  task automatic t_frame9();
    logic [10:0] b; bit ok;
    len9 = 1'b1; bit8 = 1'b1;
    wr(8'h5A);
    get_frame(11, 3*TP, b, ok);
    chk("R5 frame 9-bit b8=1", b, {1'b1, 1'b1, 8'h5A, 1'b0});
    repeat (TP) @(negedge clk);
    bit8 = 1'b0;
    wr(8'hC3);
    get_frame(11, 3*TP, b, ok);
    chk("R5 frame 9-bit b8=0", b, {1'b1, 1'b0, 8'hC3, 1'b0});
    repeat (TP) @(negedge clk);
    chk("R6 done after 9-bit", line_done, 1);
    len9 = 1'b0;
  endtask

  task automatic t_b2b();
    logic [10:0] b; bit ok; int n = 0;
    wr(8'h96);
    while (hold_empty !== 1'b1 && n < 3*TP) begin @(negedge clk); n++; end
    wr(8'h69);
    chk("R8 second queued", hold_empty, 0);
    get_frame(10, 3*TP, b, ok);
    chk("R8 first frame", b[9:0], {1'b1, 8'h96, 1'b0});
    get_frame(10, TP/2 + 3, b, ok);
    chk("R8 no gap before second", ok, 1);
    chk("R8 second frame", b[9:0], {1'b1, 8'h69, 1'b0});
    repeat (TP) @(negedge clk);
    chk("R6 both flags after pair", {hold_empty, line_done}, 2'b11);
  endtask

  task automatic t_irq();
    logic [10:0] b; bit ok;
    ie_done = 1'b1; ie_empty = 1'b0; @(negedge clk);
    chk("R7 done enabled idle", irq, 1);
    ie_done = 1'b0; @(negedge clk);
    chk("R7 none enabled", irq, 0);
    ie_empty = 1'b1; @(negedge clk);
    chk("R7 empty enabled idle", irq, 1);
    ie_empty = 1'b0; ie_done = 1'b1;
    wr(8'h11);
    chk("R7 full but idle", irq, 1);
    wait_busy();
    @(negedge clk);
    chk("R7 busy done-only", irq, 0);
    ie_empty = 1'b1; @(negedge clk);
    chk("R7 busy empty enabled", irq, 1);
    ie_done = 1'b0; ie_empty = 1'b0;
    get_frame(10, 3*TP, b, ok);
    repeat (TP) @(negedge clk);
  endtask

  task automatic t_break();
    logic [10:0] b; bit ok; int highs = 0;
    wr(8'h0F);
    wait_busy();
    brk = 1'b1;
    get_frame(10, 2, b, ok);
    chk("R9 frame finishes under break", b[9:0], {1'b1, 8'h0F, 1'b0});
    repeat (TP) @(negedge clk);
    chk("R9 line low after frame", txd, 0);
    for (int i = 0; i < 3*TP; i++) begin
      @(negedge clk);
      if (txd !== 1'b0) highs++;
    end
    chk("R9 line held low", highs, 0);
    brk = 1'b0; @(negedge clk);
    chk("R9 line released", txd, 1);
  endtask

  task automatic t_disable();
    logic [10:0] b; bit ok; int lows = 0;
    wr(8'h81);
    wait_busy();
    tx_en = 1'b0;
    wr(8'h42);
    get_frame(10, 2, b, ok);
    chk("R10 frame completes", b[9:0], {1'b1, 8'h81, 1'b0});
    repeat (TP) @(negedge clk);
    for (int i = 0; i < 30*TP; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R10 line idle when disabled", lows, 0);
    chk("R10 char still held", hold_empty, 0);
    chk("R10 done while disabled", line_done, 1);
    tx_en = 1'b1;
    get_frame(10, 2*TP, b, ok);
    chk("R10 held char after enable", b[9:0], {1'b1, 8'h42, 1'b0});
    repeat (TP) @(negedge clk);
    chk("R6 flags after resume", {hold_empty, line_done}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_frame8();
    t_ignore();
    t_frame9();
    t_b2b();
    t_irq();
    t_break();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule